// File: doc/BRIEF.md
# Off-Delay Timer with Enable, Timing and Done Flags

This block keeps a done flag high while a control input is high and for a set number of time-base ticks after that input falls. A rising input re-arms the timer at once. It raises the enable and done flags and clears the accumulated count. A falling input starts the timed interval, and the timing flag stays high for as long as the interval runs. The accumulator counts one step for each tick strobe that arrives during the interval. When the count reaches the preset, the done and timing flags drop. The count then stays at its final value until the input next rises.

The tick strobe comes from a shared divider outside the block. The preset is read as a live input. To chain several timers, the surrounding logic feeds one timer's done flag into the next timer's control input. All flags and the count are registered. Every output reflects the inputs as they were sampled at the previous rising clock edge.

Top module: `offdly_timer`

## Requirements
- R1: A synchronous reset forces the enable, timing and done flags low and the accumulator to zero on the next clock edge.
- R2: When the control input is high at a clock edge, the next outputs are: enable = 1, done = 1, timing = 0, accumulator = 0.
- R3: The enable flag equals the control input sampled at the previous clock edge, provided that edge was not a reset edge.
- R4: When the control input is low at an edge after it was held high, and the preset is non-zero, the next outputs are: timing = 1, done = 1, enable = 0, accumulator = 0.
- R5: While timing, the accumulator increases by exactly one at each edge where the tick strobe is high. At edges with no tick it keeps its value.
- R6: At the tick edge where the accumulator reaches the preset, timing and done both go low and the accumulator shows the preset value.
- R7: After expiry, with the control input low, the accumulator keeps its final value and tick strobes do not change it.
- R8: If the control input rises while timing, the timing flag clears, the accumulator clears to zero and the done flag stays high.
- R9: With a preset of zero, the falling input expires the timer at once: the next outputs show done = 0, timing = 0, accumulator = 0.
- R10: The timing flag is never high unless done is high and enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_in | input | 1 | Control input that arms and releases the timer |
| tick | input | 1 | One-cycle time-base strobe |
| preset | input | CNT_W | Number of ticks in the off-delay interval |
| en_o | output | 1 | Enable flag, the registered control input |
| tt_o | output | 1 | Timing flag, high while the interval runs |
| dn_o | output | 1 | Done flag, the delayed output |
| acc_o | output | CNT_W | Accumulated tick count |

## Verification
Each result is due exactly one clock edge after the inputs that cause it are sampled. This holds for a level change on the control input, a tick strobe, and a reset. The flags decode a single phase register, and the accumulator register updates on that same edge. The bench changes inputs a quarter period after a rising edge and waits one edge. It reads the outputs a quarter period after that edge, so each check sees the result of exactly one sampled set of inputs.

// File: rtl/offdly_pkg.sv
package offdly_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_HELD    = 2'd1,
        PH_TIMING  = 2'd2,
        PH_EXPIRED = 2'd3
    } phase_e;

    typedef struct packed {
        logic en;
        logic tt;
        logic dn;
    } flags_t;

    function automatic flags_t flags_of(phase_e ph);
        flags_t f;
        f.en = (ph == PH_HELD);
        f.tt = (ph == PH_TIMING);
        f.dn = (ph == PH_HELD) || (ph == PH_TIMING);
        return f;
    endfunction

endpackage

// File: rtl/offdly_accum.sv
module offdly_accum #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] acc,
    output logic             last_step
);
    localparam logic [CNT_W:0] ONE_X = {{CNT_W{1'b0}}, 1'b1};

    logic [CNT_W:0] acc_plus;

    assign acc_plus  = {1'b0, acc} + ONE_X;
    assign last_step = (acc_plus >= {1'b0, preset});

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= '0;
        end else if (advance && !acc_plus[CNT_W]) begin
            acc <= acc_plus[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/offdly_ctrl.sv
module offdly_ctrl
    import offdly_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ctrl_in,
    input  logic   tick,
    input  logic   last_step,
    input  logic   preset_zero,
    output phase_e phase,
    output logic   clear,
    output logic   advance
);
    phase_e phase_nx;

    always_comb begin
        phase_nx = phase;
        clear    = 1'b0;
        advance  = 1'b0;
        if (ctrl_in) begin
            phase_nx = PH_HELD;
            clear    = 1'b1;
        end else begin
            unique case (phase)
                PH_HELD:   phase_nx = preset_zero ? PH_EXPIRED : PH_TIMING;
                PH_TIMING: begin
                    if (tick) begin
                        advance = 1'b1;
                        if (last_step) phase_nx = PH_EXPIRED;
                    end
                end
                default:   phase_nx = phase;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= phase_nx;
    end
endmodule

// File: rtl/offdly_timer.sv
module offdly_timer
    import offdly_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_in,
    input  logic             tick,
    input  logic [CNT_W-1:0] preset,
    output logic             en_o,
    output logic             tt_o,
    output logic             dn_o,
    output logic [CNT_W-1:0] acc_o
);
    phase_e phase;
    flags_t flags;
    logic   clear, advance, last_step, preset_zero;

    assign preset_zero = (preset == '0);

    offdly_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ctrl_in     (ctrl_in),
        .tick        (tick),
        .last_step   (last_step),
        .preset_zero (preset_zero),
        .phase       (phase),
        .clear       (clear),
        .advance     (advance)
    );

    offdly_accum #(.CNT_W(CNT_W)) u_accum (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .advance   (advance),
        .preset    (preset),
        .acc       (acc_o),
        .last_step (last_step)
    );

    assign flags = flags_of(phase);
    assign en_o  = flags.en;
    assign tt_o  = flags.tt;
    assign dn_o  = flags.dn;

    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!en_o && !tt_o && !dn_o && acc_o == '0));

    // R2
    p_rise_arms_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl_in |=> (en_o && dn_o && !tt_o && acc_o == '0));

    // R3
    p_en_follows_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (en_o == $past(ctrl_in)));

    // R5
    p_acc_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (tt_o && !tick && !ctrl_in) |=> (acc_o == $past(acc_o)));

    // R5
    p_acc_step_r5: assert property (@(posedge clk) disable iff (rst)
        (tt_o && tick && !ctrl_in) |=> (acc_o == $past(acc_o) + 1'b1));

    // R6
    p_expire_drops_dn_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(tt_o) && !en_o) |-> !dn_o);

    // R7
    p_expired_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!en_o && !tt_o && !ctrl_in) |=> $stable(acc_o));

    // R10
    p_tt_implies_dn_r10: assert property (@(posedge clk) disable iff (rst)
        tt_o |-> (dn_o && !en_o));
endmodule

// File: tb/offdly_timer_tb.sv
module offdly_timer_tb;
    localparam int CLK_P = 10;
    localparam int W     = 8;

    logic         clk = 1'b0;
    logic         rst, ctrl_in, tick;
    logic [W-1:0] preset;
    logic         en_o, tt_o, dn_o;
    logic [W-1:0] acc_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    offdly_timer #(.CNT_W(W)) u_dut (
        .clk(clk), .rst(rst), .ctrl_in(ctrl_in), .tick(tick), .preset(preset),
        .en_o(en_o), .tt_o(tt_o), .dn_o(dn_o), .acc_o(acc_o)
    );

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic expect_out(input string req, input logic e_en, input logic e_tt,
                              input logic e_dn, input logic [W-1:0] e_acc);
        n_chk++;
        if (en_o !== e_en || tt_o !== e_tt || dn_o !== e_dn || acc_o !== e_acc) begin
            n_fail++;
            $display("FAIL %s: got en=%b tt=%b dn=%b acc=%0d, expected en=%b tt=%b dn=%b acc=%0d",
                     req, en_o, tt_o, dn_o, acc_o, e_en, e_tt, e_dn, e_acc);
        end
    endtask

    task automatic pulse_tick();
        tick = 1'b1; cyc(1); tick = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; ctrl_in = 1'b0; tick = 1'b0; preset = 8'd3;
        cyc(2);
        expect_out("R1 reset state", 0, 0, 0, 0);
        rst = 1'b0; cyc(1);
        expect_out("R1 idle after reset", 0, 0, 0, 0);
    endtask

    task automatic t_full_cycle();
        preset = 8'd3;
        ctrl_in = 1'b1; cyc(1);
        expect_out("R2 arm on high", 1, 0, 1, 0);
        tick = 1'b1; cyc(1); tick = 1'b0;
        expect_out("R3 held, ticks ignored", 1, 0, 1, 0);
        ctrl_in = 1'b0; cyc(1);
        expect_out("R4 fall starts timing", 0, 1, 1, 0);
        pulse_tick();
        expect_out("R5 first tick", 0, 1, 1, 1);
        cyc(2);
        expect_out("R5 no tick holds", 0, 1, 1, 1);
        pulse_tick();
        expect_out("R5 second tick", 0, 1, 1, 2);
        pulse_tick();
        expect_out("R6 expiry at preset", 0, 0, 0, 3);
        pulse_tick(); pulse_tick();
        expect_out("R7 final count held", 0, 0, 0, 3);
        ctrl_in = 1'b1; cyc(1);
        expect_out("R2 rise clears count", 1, 0, 1, 0);
        ctrl_in = 1'b0; cyc(1);
    endtask

    task automatic t_abort();
        preset = 8'd5;
        pulse_tick(); pulse_tick();
        expect_out("R5 counting before abort", 0, 1, 1, 2);
        ctrl_in = 1'b1; cyc(1);
        expect_out("R8 rise aborts timing", 1, 0, 1, 0);
        ctrl_in = 1'b0; cyc(1);
        expect_out("R4 restart from zero", 0, 1, 1, 0);
    endtask

    task automatic t_tick_on_fall();
        preset = 8'd2;
        ctrl_in = 1'b1; cyc(1);
        ctrl_in = 1'b0; tick = 1'b1; cyc(1);
        expect_out("R4 tick on falling edge not counted", 0, 1, 1, 0);
        cyc(1); tick = 1'b0;
        expect_out("R5 tick back to back", 0, 1, 1, 1);
        pulse_tick();
        expect_out("R6 expiry preset two", 0, 0, 0, 2);
    endtask

    task automatic t_zero_preset();
        preset = 8'd0;
        ctrl_in = 1'b1; cyc(1);
        expect_out("R2 arm zero preset", 1, 0, 1, 0);
        ctrl_in = 1'b0; cyc(1);
        expect_out("R9 immediate expiry", 0, 0, 0, 0);
        pulse_tick();
        expect_out("R7 zero preset stays expired", 0, 0, 0, 0);
    endtask

    task automatic t_reset_midway();
        preset = 8'd4;
        ctrl_in = 1'b1; cyc(1);
        ctrl_in = 1'b0; cyc(1);
        pulse_tick();
        expect_out("R5 tick before reset", 0, 1, 1, 1);
        rst = 1'b1; cyc(1);
        expect_out("R1 reset while timing", 0, 0, 0, 0);
        rst = 1'b0; cyc(1);
    endtask

    initial begin
        #(CLK_P * 5000);
        n_fail++; n_chk++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_full_cycle();
        ctrl_in = 1'b1; cyc(1); ctrl_in = 1'b0; cyc(1);
        t_abort();
        t_tick_on_fall();
        t_zero_preset();
        t_reset_midway();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule